// File: doc/BRIEF.md
# Line Sensor Drive Pulse Generator

This block drives a self-scanning photodiode-array line sensor from a fast system clock. It produces two clock phases that are never high together, a start pulse that opens each scan, and a video-line reset pulse that follows phase 2 by one cycle. Every duration is a count of system-clock cycles. The phase high width, the dead gap between phases and the line length (the integration period, counted in pixel periods) come in on configuration inputs. These inputs are checked and taken into use only at the start of a line. A set that breaks the 200 ns minimum high time or cannot give a clean start-pulse overlap is refused: the previous set stays in force and `config_error` is raised.

The sensor's end-of-scan output is brought in through a two-flop synchroniser. Its rising edge gives a one-cycle `line_done` pulse and returns the pixel index to zero. A downstream sampler takes `px_strobe`, which marks each rising edge of phase 2 (one pixel per phase-2 period), together with `px_index`.

The sequencer is a state machine. `IDLE` moves to `PH1` when enable is high, and that `PH1` opens a start pixel. `PH1` moves to `GAP1`, or straight to `PH2` when the gap count is zero. `GAP1` moves to `PH2`. `PH2` moves to `GAP2`, or ends the pixel when the gap count is zero. `GAP2` ends the pixel. At the end of a pixel the machine goes to `IDLE` if enable is low, to a start pixel `PH1` if the line count is used up, and otherwise to a plain `PH1`.

Top module: `lsens_drive_gen`

## Requirements
- R1: While rst_n is low at a clock edge, st_out, ph1_out, ph2_out, vrst_out, px_strobe, line_done and config_error are 0 and px_index is 0 after that edge. With enable low after reset, all of them stay low.
- R2: One cycle after enable is sampled high in the idle state, st_out and ph1_out rise in the same cycle.
- R3: ph1_out and ph2_out are never high in the same cycle. Each high pulse of either phase lasts exactly the active high count, in cycles.
- R4: Each phase falls and the other phase rises after exactly the active gap count of cycles with both low. A gap of 0 makes the phases complementary. Successive phase-2 rising edges are 2*(high+gap) cycles apart.
- R5: st_out stays high for 2*(high+gap)+1 cycles. It overlaps ph2_out high for exactly the high count, and ph2_out falls exactly once while st_out is high.
- R6: st_out rises every line-count pixel periods, i.e. every line*2*(high+gap) cycles.
- R7: vrst_out is ph2_out delayed by one cycle. It rises only while ph2_out is high, falls only while ph2_out is low, and gives one pulse per pixel.
- R8: px_strobe is a one-cycle pulse in exactly the first cycle that ph2_out is high. During the strobe, px_index holds the pixel number, and it advances by one after each strobe.
- R9: If eos_in is first sampled high at clock edge k, line_done is high for exactly the one cycle after edge k+1. px_index then reads 0, and the next strobe reports pixel 0.
- R10: Configuration inputs changed during a line do not affect the timing of that line. They are examined only at the clock edge where st_out rises.
- R11: At that edge, a set with high count below MIN_HI or line count below 2 sets config_error and keeps the previous timing. A valid set is taken into use and clears config_error.
- R12: When enable goes low, the current pixel period is completed and all drive outputs then stay low. Raising enable again restarts with st_out and ph1_out together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request for the pulse sequence |
| cfg_high_cnt | input | CW | Phase high width in cycles |
| cfg_gap_cnt | input | CW | Dead gap between phases in cycles |
| cfg_line_pix | input | CW | Pixel periods between start pulses |
| eos_in | input | 1 | Asynchronous end-of-scan from the sensor |
| st_out | output | 1 | Scan start pulse |
| ph1_out | output | 1 | Clock phase 1 |
| ph2_out | output | 1 | Clock phase 2 |
| vrst_out | output | 1 | Video-line reset pulse |
| px_strobe | output | 1 | Pixel sample strobe at each phase-2 rise |
| px_index | output | IW | Pixel number within the line |
| line_done | output | 1 | One-cycle end-of-line pulse |
| config_error | output | 1 | Last checked configuration was refused |

## Verification
A wrong state or counter in the sequencer appears at the ports within one pixel period. It shows as a phase pulse of the wrong length, a wrong dead gap, overlapping phases, or a start pulse whose overlap with phase 2 is not the high count. A fault in the line counter or in the configuration latch appears at the next start pulse, as a wrong start interval or a wrong `config_error` value. A fault in the end-of-scan path appears two cycles after the input rises, as a missing or doubled `line_done`, and at the next strobe, as a non-zero index.

// File: rtl/lsens_pkg.sv
package lsens_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PH1,
        ST_GAP1,
        ST_PH2,
        ST_GAP2
    } drv_state_e;
endpackage

// File: rtl/lsens_cfg_hold.sv
module lsens_cfg_hold #(
    parameter int CW       = 16,
    parameter int MIN_HI   = 50,
    parameter int DEF_HI   = 50,
    parameter int DEF_GAP  = 2,
    parameter int DEF_LINE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] cfg_hi,
    input  logic [CW-1:0] cfg_gap,
    input  logic [CW-1:0] cfg_line,
    output logic [CW-1:0] act_hi,
    output logic [CW-1:0] act_gap,
    output logic [CW-1:0] act_line,
    output logic          cfg_err
);
    localparam logic [CW-1:0] HI_FLOOR   = CW'(MIN_HI);
    localparam logic [CW-1:0] LINE_FLOOR = CW'(2);

    logic set_ok;
    assign set_ok = (cfg_hi >= HI_FLOOR) && (cfg_line >= LINE_FLOOR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_hi   <= CW'(DEF_HI);
            act_gap  <= CW'(DEF_GAP);
            act_line <= CW'(DEF_LINE);
            cfg_err  <= 1'b0;
        end else if (load) begin
            if (set_ok) begin
                act_hi   <= cfg_hi;
                act_gap  <= cfg_gap;
                act_line <= cfg_line;
                cfg_err  <= 1'b0;
            end else begin
                cfg_err  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsens_phase_fsm.sv
module lsens_phase_fsm
    import lsens_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [CW-1:0] act_hi,
    input  logic [CW-1:0] act_gap,
    input  logic [CW-1:0] act_line,
    output logic          load,
    output logic          ph1,
    output logic          ph2,
    output logic          st,
    output logic          vrst,
    output logic          strobe
);
    localparam logic [CW-1:0] ONE = CW'(1);

    drv_state_e    state, nxt_state;
    logic [CW-1:0] cnt, nxt_cnt;
    logic [CW-1:0] line_cnt, nxt_line;
    logic          start_px, nxt_start;
    logic          tail_q, vrst_q;
    logic          pix_end;
    logic [CW-1:0] hi_last, gap_last, line_last;
    logic          gap_zero;

    assign hi_last   = act_hi - ONE;
    assign gap_last  = act_gap - ONE;
    assign line_last = act_line - ONE;
    assign gap_zero  = (act_gap == '0);

    // next-state selection
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt + ONE;
        nxt_line  = line_cnt;
        nxt_start = start_px;
        pix_end   = 1'b0;
        load      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                nxt_cnt = '0;
                if (enable) begin
                    nxt_state = ST_PH1;
                    nxt_start = 1'b1;
                    nxt_line  = '0;
                    load      = 1'b1;
                end
            end
            ST_PH1: begin
                if (cnt == hi_last) begin
                    nxt_cnt   = '0;
                    nxt_state = gap_zero ? ST_PH2 : ST_GAP1;
                end
            end
            ST_GAP1: begin
                if (cnt == gap_last) begin
                    nxt_cnt   = '0;
                    nxt_state = ST_PH2;
                end
            end
            ST_PH2: begin
                if (cnt == hi_last) begin
                    nxt_cnt = '0;
                    if (gap_zero) pix_end = 1'b1;
                    else          nxt_state = ST_GAP2;
                end
            end
            ST_GAP2: begin
                if (cnt == gap_last) begin
                    nxt_cnt = '0;
                    pix_end = 1'b1;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
        if (pix_end) begin
            if (!enable) begin
                nxt_state = ST_IDLE;
                nxt_start = 1'b0;
            end else if (line_cnt == line_last) begin
                nxt_state = ST_PH1;
                nxt_start = 1'b1;
                nxt_line  = '0;
                load      = 1'b1;
            end else begin
                nxt_state = ST_PH1;
                nxt_start = 1'b0;
                nxt_line  = line_cnt + ONE;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            line_cnt <= '0;
            start_px <= 1'b0;
            tail_q   <= 1'b0;
            vrst_q   <= 1'b0;
        end else begin
            state    <= nxt_state;
            cnt      <= nxt_cnt;
            line_cnt <= nxt_line;
            start_px <= nxt_start;
            tail_q   <= pix_end && start_px;
            vrst_q   <= (state == ST_PH2);
        end
    end

    // output decode
    always_comb begin
        ph1    = (state == ST_PH1);
        ph2    = (state == ST_PH2);
        strobe = (state == ST_PH2) && (cnt == '0);
        st     = (start_px && (state != ST_IDLE)) || tail_q;
        vrst   = vrst_q;
    end
endmodule

// File: rtl/lsens_eos_sync.sv
module lsens_eos_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eos_async,
    output logic eos_edge
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], eos_async};
    end

    assign eos_edge = pipe[STAGES-1] && !pipe[STAGES];
endmodule

// File: rtl/lsens_pix_track.sv
module lsens_pix_track #(
    parameter int IW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          clear,
    output logic [IW-1:0] idx
);
    always_ff @(posedge clk) begin
        if (!rst_n)      idx <= '0;
        else if (clear)  idx <= '0;
        else if (strobe) idx <= idx + IW'(1);
    end
endmodule

// File: rtl/lsens_drive_gen.sv
module lsens_drive_gen #(
    parameter int CW       = 16,
    parameter int IW       = 10,
    parameter int MIN_HI   = 50,
    parameter int DEF_HI   = 50,
    parameter int DEF_GAP  = 2,
    parameter int DEF_LINE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [CW-1:0] cfg_high_cnt,
    input  logic [CW-1:0] cfg_gap_cnt,
    input  logic [CW-1:0] cfg_line_pix,
    input  logic          eos_in,
    output logic          st_out,
    output logic          ph1_out,
    output logic          ph2_out,
    output logic          vrst_out,
    output logic          px_strobe,
    output logic [IW-1:0] px_index,
    output logic          line_done,
    output logic          config_error
);
    logic          load;
    logic [CW-1:0] act_hi, act_gap, act_line;

    lsens_cfg_hold #(
        .CW(CW), .MIN_HI(MIN_HI), .DEF_HI(DEF_HI),
        .DEF_GAP(DEF_GAP), .DEF_LINE(DEF_LINE)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(load),
        .cfg_hi(cfg_high_cnt), .cfg_gap(cfg_gap_cnt), .cfg_line(cfg_line_pix),
        .act_hi(act_hi), .act_gap(act_gap), .act_line(act_line),
        .cfg_err(config_error)
    );

    lsens_phase_fsm #(.CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .act_hi(act_hi), .act_gap(act_gap), .act_line(act_line),
        .load(load), .ph1(ph1_out), .ph2(ph2_out), .st(st_out),
        .vrst(vrst_out), .strobe(px_strobe)
    );

    lsens_eos_sync #(.STAGES(2)) u_eos (
        .clk(clk), .rst_n(rst_n), .eos_async(eos_in), .eos_edge(line_done)
    );

    lsens_pix_track #(.IW(IW)) u_pix (
        .clk(clk), .rst_n(rst_n), .strobe(px_strobe),
        .clear(line_done), .idx(px_index)
    );
endmodule

// File: rtl/lsens_drive_chk.sv
module lsens_drive_chk #(
    parameter int IW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_out,
    input logic          ph1_out,
    input logic          ph2_out,
    input logic          vrst_out,
    input logic          px_strobe,
    input logic [IW-1:0] px_index,
    input logic          line_done
);
    p_phase_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph1_out && ph2_out));

    p_vrst_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vrst_out) |-> ph2_out);

    p_vrst_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vrst_out) |-> !ph2_out);

    p_strobe_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        px_strobe |-> (ph2_out && !$past(ph2_out)));

    p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (px_strobe && !line_done) |=> (px_index == IW'($past(px_index) + 1'b1)));

    p_st_with_ph1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_out) |-> $rose(ph1_out));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);

    p_idx_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> (px_index == '0));
endmodule

bind lsens_drive_gen lsens_drive_chk #(.IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .st_out(st_out), .ph1_out(ph1_out),
    .ph2_out(ph2_out), .vrst_out(vrst_out), .px_strobe(px_strobe),
    .px_index(px_index), .line_done(line_done)
);

// File: tb/lsens_drive_gen_tb_top.sv
`timescale 1ns/1ps
module lsens_drive_gen_tb_top;
    localparam int CW = 16;
    localparam int IW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [CW-1:0] cfg_high_cnt = 16'd50;
    logic [CW-1:0] cfg_gap_cnt  = 16'd2;
    logic [CW-1:0] cfg_line_pix = 16'd4;
    logic          eos_in = 1'b0;
    logic          st_out, ph1_out, ph2_out, vrst_out, px_strobe, line_done, config_error;
    logic [IW-1:0] px_index;

    always #2 clk = ~clk;

    lsens_drive_gen #(.CW(CW), .IW(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_high_cnt(cfg_high_cnt), .cfg_gap_cnt(cfg_gap_cnt), .cfg_line_pix(cfg_line_pix),
        .eos_in(eos_in), .st_out(st_out), .ph1_out(ph1_out), .ph2_out(ph2_out),
        .vrst_out(vrst_out), .px_strobe(px_strobe), .px_index(px_index),
        .line_done(line_done), .config_error(config_error)
    );

    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // port monitor and scoreboard
    int cyc = 0;
    bit ph1_p = 0, ph2_p = 0, st_p = 0, vr_p = 0;
    int ph1_run = 0, ph2_run = 0, dead_run = 0;
    int last_ph1 = 0, last_ph2 = 0, last_dead = 0, last_period = 0;
    int t_ph2 = 0, t_st = 0, last_st_len = 0, last_st_int = 0;
    int ov_run = 0, fall_run = 0, last_ov = 0, last_falls = 0;
    bit ph2_seen = 0, st_seen = 0;
    int ph2_rises = 0, vrst_rises = 0;
    bit both_hi = 0, bad_vr_rise = 0, bad_vr_fall = 0, bad_strobe = 0;

    always @(negedge clk) begin
        cyc++;
        if (ph1_out) ph1_run++;
        else if (ph1_p) begin last_ph1 = ph1_run; ph1_run = 0; end
        if (ph2_out) ph2_run++;
        else if (ph2_p) begin last_ph2 = ph2_run; ph2_run = 0; end
        if (!ph1_out && !ph2_out) dead_run++;
        else if (dead_run != 0) begin last_dead = dead_run; dead_run = 0; end
        if (ph2_out && !ph2_p) begin
            if (ph2_seen) last_period = cyc - t_ph2;
            t_ph2 = cyc; ph2_seen = 1; ph2_rises++;
        end
        if (st_out && !st_p) begin
            if (st_seen) last_st_int = cyc - t_st;
            t_st = cyc; st_seen = 1; ov_run = 0; fall_run = 0;
        end
        if (st_out && ph2_out) ov_run++;
        if (st_out && ph2_p && !ph2_out) fall_run++;
        if (!st_out && st_p) begin
            last_st_len = cyc - t_st; last_ov = ov_run; last_falls = fall_run;
        end
        if (vrst_out && !vr_p) begin vrst_rises++; if (!ph2_out) bad_vr_rise = 1; end
        if (!vrst_out && vr_p && ph2_out) bad_vr_fall = 1;
        if (ph1_out && ph2_out) both_hi = 1;
        if (px_strobe != (ph2_out && !ph2_p)) bad_strobe = 1;
        if (px_strobe && exp_q.size() > 0) begin
            int e;
            e = exp_q.pop_front();
            chk(int'(px_index) == e, "R8 pixel index at strobe", int'(px_index), e);
        end
        ph1_p = ph1_out; ph2_p = ph2_out; st_p = st_out; vr_p = vrst_out;
    end

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    task automatic wait_st_rise;
        bit p;
        p = st_out; tick();
        while (!(st_out && !p)) begin p = st_out; tick(); end
    endtask

    task automatic wait_st_fall;
        bit p;
        p = st_out; tick();
        while (!(!st_out && p)) begin p = st_out; tick(); end
    endtask

    task automatic wait_ph2_rise;
        bit p;
        p = ph2_out; tick();
        while (!(ph2_out && !p)) begin p = ph2_out; tick(); end
    endtask

    task automatic push_pixels(input int first, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(first + i);
    endtask

    task automatic drain;
        while (exp_q.size() != 0) tick();
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int hi_cnt;
        // R1 reset state
        repeat (5) tick();
        chk({st_out, ph1_out, ph2_out, vrst_out, px_strobe, line_done, config_error} == 7'b0,
            "R1 outputs in reset", {st_out, ph1_out, ph2_out, vrst_out}, 0);
        chk(px_index == '0, "R1 index in reset", int'(px_index), 0);
        rst_n = 1'b1;
        hi_cnt = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (st_out || ph1_out || ph2_out || vrst_out) hi_cnt++;
        end
        chk(hi_cnt == 0, "R1 idle with enable low", hi_cnt, 0);

        // R2 start, R3-R6 default timing, R8 indexing
        push_pixels(0, 6);
        enable = 1'b1;
        tick();
        chk(st_out && ph1_out, "R2 st and ph1 rise together", {st_out, ph1_out}, 3);
        chk(!config_error, "R11 defaults valid", config_error, 0);
        drain();
        chk(last_ph1 == 50, "R3 ph1 width", last_ph1, 50);
        chk(last_ph2 == 50, "R3 ph2 width", last_ph2, 50);
        chk(last_dead == 2, "R4 dead gap", last_dead, 2);
        chk(last_period == 104, "R4 pixel period", last_period, 104);
        chk(last_st_len == 105, "R5 st width", last_st_len, 105);
        chk(last_ov == 50, "R5 st overlap with ph2", last_ov, 50);
        chk(last_falls == 1, "R5 ph2 falls once in st", last_falls, 1);
        chk(last_st_int == 416, "R6 start interval", last_st_int, 416);

        // R10 mid-line change has no effect; R11 refusal
        wait_st_fall();
        cfg_high_cnt = 16'd49;
        wait_ph2_rise();
        wait_ph2_rise();
        chk(last_period == 104, "R10 period unchanged mid-line", last_period, 104);
        chk(!config_error, "R10 no check mid-line", config_error, 0);
        wait_st_rise();
        chk(config_error, "R11 short high refused", config_error, 1);
        wait_ph2_rise();
        wait_ph2_rise();
        chk(last_period == 104, "R11 old period kept", last_period, 104);
        chk(last_ph1 == 50, "R11 old width kept", last_ph1, 50);
        cfg_high_cnt = 16'd50;
        cfg_line_pix = 16'd1;
        wait_st_rise();
        chk(config_error, "R11 short line refused", config_error, 1);
        wait_st_rise();
        chk(last_st_int == 416, "R11 old line kept", last_st_int, 416);

        // R11 accept, R4 complementary gap 0
        cfg_high_cnt = 16'd60;
        cfg_gap_cnt  = 16'd0;
        cfg_line_pix = 16'd3;
        wait_st_rise();
        chk(!config_error, "R11 valid set clears error", config_error, 0);
        wait_ph2_rise();
        wait_ph2_rise();
        chk(last_period == 120, "R4 complementary period", last_period, 120);
        chk(last_ph1 == 60, "R3 new ph1 width", last_ph1, 60);
        chk(last_st_len == 121, "R5 st width gap 0", last_st_len, 121);
        chk(last_ov == 60, "R5 overlap gap 0", last_ov, 60);
        chk(last_falls == 1, "R5 single ph2 fall gap 0", last_falls, 1);
        wait_st_rise();
        chk(last_st_int == 360, "R6 start interval new", last_st_int, 360);

        // R9 end of scan
        wait_ph2_rise();
        eos_in = 1'b1;
        tick();
        chk(!line_done, "R9 line_done not early", line_done, 0);
        tick();
        chk(line_done, "R9 line_done latency", line_done, 1);
        tick();
        chk(!line_done, "R9 line_done single cycle", line_done, 0);
        chk(px_index == '0, "R9 index cleared", int'(px_index), 0);
        push_pixels(0, 3);
        eos_in = 1'b0;
        drain();

        // R12 stop and restart
        enable = 1'b0;
        repeat (200) tick();
        hi_cnt = 0;
        for (int i = 0; i < 50; i++) begin
            tick();
            if (st_out || ph1_out || ph2_out || vrst_out) hi_cnt++;
        end
        chk(hi_cnt == 0, "R12 outputs low after stop", hi_cnt, 0);
        enable = 1'b1;
        tick();
        chk(st_out && ph1_out, "R12 restart with start pulse", {st_out, ph1_out}, 3);

        // sticky port observations
        chk(!both_hi, "R3 phases never overlap", both_hi, 0);
        chk(!bad_vr_rise && !bad_vr_fall, "R7 reset pulse placement", {bad_vr_rise, bad_vr_fall}, 0);
        chk(vrst_rises == ph2_rises, "R7 one reset pulse per pixel", vrst_rises, ph2_rises);
        chk(!bad_strobe, "R8 strobe at ph2 rise only", bad_strobe, 0);
        finish_run();
    end
endmodule